// File: doc/BRIEF.md
# Locality-Aware L2 Replacement Controller

This block owns the tag side of one set-associative second-level cache. Every access brings a set index, an address tag and the program counter of the instruction that issued it. The block reports whether the tag is present and which way holds it. On a miss it names the way to be refilled and installs the new tag there. The data array, the path to memory and coherence sit outside the block.

Replacement is not plain least-recently-used. A small table, indexed by instruction PC, learns at run time which instructions reuse their lines. A hit below the most-recent stack position trains the entry of the instruction that last touched the line. A hit at the top of the stack untrains it. Each access copies the prediction for its own PC into the line's temporal bit. On a miss, the victim logic skips lines whose temporal bit is set where it can.

Top module: `lpr_ctrl`

## Requirements
- R1: `req_ready` is held high and one access can be accepted per cycle. An access accepted at a rising edge has its result on `rsp_valid`, `rsp_hit`, `rsp_hit_way` and `rsp_victim_way` from that edge until the next one. `rsp_valid` is low in the cycle after any edge with no accepted access, including the edges during reset.
- R2: An access hits when a valid line in the addressed set holds an equal tag. A hit reports `rsp_hit`=1, the way number on `rsp_hit_way` and 0 on `rsp_victim_way`. A miss reports `rsp_hit`=0 and `rsp_hit_way`=0.
- R3: Each set keeps a true recency rank per way, where 0 is most recent and WAYS-1 is least recent. The ranks always form a permutation of 0..WAYS-1. After reset each way's rank equals its way number. The accessed or filled way moves to rank 0, and every way that was more recent than it moves down by one.
- R4: On a miss with any invalid way in the set, the victim is the lowest-numbered invalid way.
- R5: On a miss in a full set, the victim is the least recent way whose temporal bit is clear.
- R6: On a miss in a full set where every temporal bit is set, the victim is the way with rank WAYS-1.
- R7: A hit to a line with a rank other than 0 sets the locality-table entry addressed by the PC index stored with that line. The index is PC bits [7:2] and the table has 64 entries.
- R8: A hit to the line with rank 0 clears the locality-table entry addressed by that line's stored PC index.
- R9: On every accepted access, the touched line's temporal bit takes the table entry for the current PC's index, read before this access's own table update. The line's stored PC index becomes the current PC's index.
- R10: A miss leaves the locality table unchanged, installs the tag and marks the line valid. Reset clears every valid bit, temporal bit, stored PC index and table entry.
- R11: An access to the same set in the very next cycle sees all state written by the previous access. This covers tag, valid, rank, temporal bit and table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take an access this cycle |
| req_set | input | $clog2(SETS) | Set index of the access |
| req_tag | input | TAG_W | Address tag of the access |
| req_pc | input | PC_W | PC of the issuing instruction |
| rsp_valid | output | 1 | Result of the access accepted at the last edge |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_hit_way | output | $clog2(WAYS) | Way that hit |
| rsp_victim_way | output | $clog2(WAYS) | Way chosen and refilled on a miss |

## Verification
One directed case checks that a full set whose least recent line is temporal gives up an older non-temporal line instead. A design that fell back to plain LRU would name the wrong way there. Another case fills a set with lines from one PC after that PC's entry was trained. This reaches the all-temporal fallback, where a design without the rank fallback would pick an arbitrary way. A third case checks that a repeated hit at the top of the stack untrains the table. A design missing that clear would later see every way as temporal and evict the LRU line. Back-to-back accesses to one set show whether the second access reads stale rank or tag state. Random traffic then uses a few sets, tags and PCs so that hits, refills and table aliasing happen often.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

   // Kind of access as seen by the locality-table update path.
   typedef enum logic [1:0] {
      KIND_FILL     = 2'd0,
      KIND_HIT_TOP  = 2'd1,
      KIND_HIT_DEEP = 2'd2
   } lpr_kind_e;

   // True when v is a power of two and at least two.
   function automatic bit pow2_ok(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lpr_rank_update.sv
// Moves one way to rank 0 and ages every way that was more recent than it.
module lpr_rank_update #(
   parameter int WAYS  = 4,
   parameter int WAY_W = $clog2(WAYS)
)(
   input  logic [WAYS-1:0][WAY_W-1:0] rank_i,
   input  logic [WAY_W-1:0]           touch_i,
   output logic [WAYS-1:0][WAY_W-1:0] rank_o
);
   logic [WAY_W-1:0] touch_rank;
   assign touch_rank = rank_i[touch_i];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_comb begin
         if (WAY_W'(w) == touch_i) begin
            rank_o[w] = '0;
         end else if (rank_i[w] < touch_rank) begin
            rank_o[w] = rank_i[w] + WAY_W'(1);
         end else begin
            rank_o[w] = rank_i[w];
         end
      end
   end
endmodule

// File: rtl/lpr_victim_pick.sv
// Chooses the way to refill on a miss.
module lpr_victim_pick #(
   parameter int WAYS        = 4,
   parameter bit LOCALITY_EN = 1'b1,
   parameter int WAY_W       = $clog2(WAYS)
)(
   input  logic [WAYS-1:0]            valid_i,
   input  logic [WAYS-1:0]            temp_i,
   input  logic [WAYS-1:0][WAY_W-1:0] rank_i,
   output logic [WAY_W-1:0]           victim_o
);
   logic             inv_found;
   logic [WAY_W-1:0] inv_way;
   logic [WAY_W-1:0] lru_way;

   // lowest-numbered invalid way
   always_comb begin
      inv_found = 1'b0;
      inv_way   = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_i[w]) begin
            inv_found = 1'b1;
            inv_way   = WAY_W'(w);
         end
      end
   end

   // way holding the oldest rank
   always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (rank_i[w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
      end
   end

   if (LOCALITY_EN) begin : g_locality
      logic             cold_found;
      logic [WAY_W-1:0] cold_way;

      // walk ranks from newest to oldest; the last cold way seen is the oldest
      always_comb begin
         cold_found = 1'b0;
         cold_way   = '0;
         for (int p = 0; p < WAYS; p++) begin
            for (int w = 0; w < WAYS; w++) begin
               if (rank_i[w] == WAY_W'(p) && !temp_i[w]) begin
                  cold_found = 1'b1;
                  cold_way   = WAY_W'(w);
               end
            end
         end
      end

      always_comb begin
         if (inv_found)       victim_o = inv_way;
         else if (cold_found) victim_o = cold_way;
         else                 victim_o = lru_way;
      end
   end else begin : g_plain
      logic unused_temp;
      assign unused_temp = ^temp_i;

      always_comb begin
         if (inv_found) victim_o = inv_way;
         else           victim_o = lru_way;
      end
   end
endmodule

// File: rtl/lpr_loc_table.sv
// One-bit-per-entry locality predictor, read combinationally, written at the edge.
module lpr_loc_table #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = $clog2(ENTRIES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_bit
);
   logic [ENTRIES-1:0] bits_q;

   assign rd_bit = bits_q[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (wr_en) begin
         bits_q[wr_idx] <= wr_bit;
      end
   end
endmodule

// File: rtl/lpr_ctrl.sv
module lpr_ctrl
   import lpr_pkg::*;
#(
   parameter int WAYS        = 4,
   parameter int SETS        = 16,
   parameter int TAG_W       = 20,
   parameter int PC_W        = 32,
   parameter int LT_ENTRIES  = 64,
   parameter int PC_LSB      = 2,
   parameter bit LOCALITY_EN = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [$clog2(SETS)-1:0] req_set,
   input  logic [TAG_W-1:0]        req_tag,
   input  logic [PC_W-1:0]         req_pc,
   output logic                    rsp_valid,
   output logic                    rsp_hit,
   output logic [$clog2(WAYS)-1:0] rsp_hit_way,
   output logic [$clog2(WAYS)-1:0] rsp_victim_way
);
   localparam int WAY_W    = $clog2(WAYS);
   localparam int SET_W    = $clog2(SETS);
   localparam int LT_IDX_W = $clog2(LT_ENTRIES);
   localparam int PC_TOP   = PC_LSB + LT_IDX_W;

   // ---------------- elaboration checks ----------------
   if (!pow2_ok(WAYS)) begin : g_bad_ways
      $error("lpr_ctrl: WAYS must be a power of two, at least 2");
   end
   if (!pow2_ok(SETS)) begin : g_bad_sets
      $error("lpr_ctrl: SETS must be a power of two, at least 2");
   end
   if (!pow2_ok(LT_ENTRIES)) begin : g_bad_lt
      $error("lpr_ctrl: LT_ENTRIES must be a power of two, at least 2");
   end
   if (PC_LSB < 1 || PC_TOP >= PC_W) begin : g_bad_pc
      $error("lpr_ctrl: PC index field must lie strictly inside the PC");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("lpr_ctrl: TAG_W must be positive");
   end

   // ---------------- per-line state ----------------
   logic                valid_q [SETS][WAYS];
   logic [TAG_W-1:0]    tag_q   [SETS][WAYS];
   logic [LT_IDX_W-1:0] pct_q   [SETS][WAYS];
   logic                temp_q  [SETS][WAYS];
   logic [WAY_W-1:0]    rank_q  [SETS][WAYS];

   // ---------------- addressed-set view ----------------
   logic [WAYS-1:0]                sel_valid;
   logic [WAYS-1:0]                sel_temp;
   logic [WAYS-1:0]                match;
   logic [WAYS-1:0][WAY_W-1:0]     sel_rank;
   logic [WAYS-1:0][LT_IDX_W-1:0]  sel_pct;

   for (genvar w = 0; w < WAYS; w++) begin : g_sel
      assign sel_valid[w] = valid_q[req_set][w];
      assign sel_temp[w]  = temp_q[req_set][w];
      assign sel_rank[w]  = rank_q[req_set][w];
      assign sel_pct[w]   = pct_q[req_set][w];
      assign match[w]     = valid_q[req_set][w] && (tag_q[req_set][w] == req_tag);
   end

   logic                fire;
   logic                hit_any;
   logic [WAY_W-1:0]    hit_way;
   logic [WAY_W-1:0]    victim_way;
   logic [WAY_W-1:0]    touch_way;
   logic [LT_IDX_W-1:0] pc_idx;
   logic                unused_pc_bits;
   lpr_kind_e           kind;

   assign req_ready      = 1'b1;
   assign fire           = req_valid && req_ready;
   assign pc_idx         = req_pc[PC_LSB +: LT_IDX_W];
   assign unused_pc_bits = ^{req_pc[PC_W-1:PC_TOP], req_pc[PC_LSB-1:0]};
   assign hit_any        = |match;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end

   always_comb begin
      if (!hit_any)                   kind = KIND_FILL;
      else if (sel_rank[hit_way] == '0) kind = KIND_HIT_TOP;
      else                            kind = KIND_HIT_DEEP;
   end

   // ---------------- victim selection ----------------
   lpr_victim_pick #(
      .WAYS        (WAYS),
      .LOCALITY_EN (LOCALITY_EN),
      .WAY_W       (WAY_W)
   ) u_pick (
      .valid_i  (sel_valid),
      .temp_i   (sel_temp),
      .rank_i   (sel_rank),
      .victim_o (victim_way)
   );

   assign touch_way = hit_any ? hit_way : victim_way;

   // ---------------- recency update ----------------
   logic [WAYS-1:0][WAY_W-1:0] rank_new;

   lpr_rank_update #(
      .WAYS  (WAYS),
      .WAY_W (WAY_W)
   ) u_rank (
      .rank_i  (sel_rank),
      .touch_i (touch_way),
      .rank_o  (rank_new)
   );

   // ---------------- locality table ----------------
   logic                lt_rd_bit;
   logic                lt_wr_en;
   logic [LT_IDX_W-1:0] lt_wr_idx;
   logic                lt_wr_bit;

   assign lt_wr_en  = fire && (kind != KIND_FILL);
   assign lt_wr_idx = sel_pct[hit_way];
   assign lt_wr_bit = (kind == KIND_HIT_DEEP);

   lpr_loc_table #(
      .ENTRIES (LT_ENTRIES),
      .IDX_W   (LT_IDX_W)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pc_idx),
      .rd_bit (lt_rd_bit),
      .wr_en  (lt_wr_en),
      .wr_idx (lt_wr_idx),
      .wr_bit (lt_wr_bit)
   );

   // ---------------- state and result registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               valid_q[s][w] <= 1'b0;
               tag_q[s][w]   <= '0;
               pct_q[s][w]   <= '0;
               temp_q[s][w]  <= 1'b0;
               rank_q[s][w]  <= WAY_W'(w);
            end
         end
         rsp_valid      <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_hit_way    <= '0;
         rsp_victim_way <= '0;
      end else begin
         rsp_valid <= fire;
         if (fire) begin
            valid_q[req_set][touch_way] <= 1'b1;
            tag_q[req_set][touch_way]   <= req_tag;
            pct_q[req_set][touch_way]   <= pc_idx;
            temp_q[req_set][touch_way]  <= lt_rd_bit;
            for (int w = 0; w < WAYS; w++) begin
               rank_q[req_set][w] <= rank_new[w];
            end
            rsp_hit        <= hit_any;
            rsp_hit_way    <= hit_any ? hit_way : '0;
            rsp_victim_way <= hit_any ? '0 : victim_way;
         end
      end
   end

endmodule

// File: rtl/lpr_ctrl_chk.sv
module lpr_ctrl_chk #(
   parameter int WAYS        = 4,
   parameter int SET_W       = 4,
   parameter int TAG_W       = 20,
   parameter bit LOCALITY_EN = 1'b1,
   parameter int WAY_W       = $clog2(WAYS)
)(
   input logic                       clk,
   input logic                       rst_n,
   input logic                       fire,
   input logic                       hit_any,
   input logic [SET_W-1:0]           req_set,
   input logic [TAG_W-1:0]           req_tag,
   input logic [WAY_W-1:0]           touch_way,
   input logic [WAY_W-1:0]           victim_way,
   input logic [WAYS-1:0]            sel_valid,
   input logic [WAYS-1:0]            sel_temp,
   input logic [WAYS-1:0][WAY_W-1:0] sel_rank,
   input logic                       rsp_valid
);
   logic [WAYS-1:0] rank_seen;
   always_comb begin
      rank_seen = '0;
      for (int w = 0; w < WAYS; w++) rank_seen[sel_rank[w]] = 1'b1;
   end

   a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_valid);

   a_r1_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !rsp_valid);

   a_r3_rank_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (&rank_seen));

   a_r4_victim_is_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !hit_any && !(&sel_valid)) |-> !sel_valid[victim_way]);

   a_r5_victim_is_cold: assert property (@(posedge clk) disable iff (!rst_n)
      (LOCALITY_EN && fire && !hit_any && (&sel_valid) && !(&sel_temp))
         |-> !sel_temp[victim_way]);

   a_r6_victim_is_lru: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !hit_any && (&sel_valid) && (&sel_temp))
         |-> (sel_rank[victim_way] == WAY_W'(WAYS - 1)));

   a_r11_touch_is_mru_next: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && $past(fire) && (req_set == $past(req_set)))
         |-> (sel_rank[$past(touch_way)] == '0));

   a_r11_repeat_tag_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && $past(fire) && (req_set == $past(req_set)) && (req_tag == $past(req_tag)))
         |-> hit_any);
endmodule

bind lpr_ctrl lpr_ctrl_chk #(
   .WAYS        (WAYS),
   .SET_W       ($clog2(SETS)),
   .TAG_W       (TAG_W),
   .LOCALITY_EN (LOCALITY_EN)
) u_lpr_ctrl_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fire       (fire),
   .hit_any    (hit_any),
   .req_set    (req_set),
   .req_tag    (req_tag),
   .touch_way  (touch_way),
   .victim_way (victim_way),
   .sel_valid  (sel_valid),
   .sel_temp   (sel_temp),
   .sel_rank   (sel_rank),
   .rsp_valid  (rsp_valid)
);

// File: tb/lpr_ctrl_bench.sv
module lpr_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 4;
   localparam int NS = 16;
   localparam int TW = 20;
   localparam int NLT = 64;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [3:0]    req_set;
   logic [TW-1:0] req_tag;
   logic [31:0]   req_pc;
   logic          rsp_valid;
   logic          rsp_hit;
   logic [1:0]    rsp_hit_way;
   logic [1:0]    rsp_victim_way;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lpr_ctrl u_lpr_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_set        (req_set),
      .req_tag        (req_tag),
      .req_pc         (req_pc),
      .rsp_valid      (rsp_valid),
      .rsp_hit        (rsp_hit),
      .rsp_hit_way    (rsp_hit_way),
      .rsp_victim_way (rsp_victim_way)
   );

   int checks = 0;
   int fails  = 0;

   // ---------------- behavioural reference ----------------
   bit          m_valid [NS][NW];
   bit [TW-1:0] m_tag   [NS][NW];
   int          m_pct   [NS][NW];
   bit          m_temp  [NS][NW];
   int          m_stack [NS][NW];   // m_stack[s][0] is the most recent way
   bit          m_table [NLT];

   function automatic void model_reset();
      for (int s = 0; s < NS; s++) begin
         for (int w = 0; w < NW; w++) begin
            m_valid[s][w] = 0;
            m_tag[s][w]   = '0;
            m_pct[s][w]   = 0;
            m_temp[s][w]  = 0;
            m_stack[s][w] = w;
         end
      end
      for (int i = 0; i < NLT; i++) m_table[i] = 0;
   endfunction

   function automatic void model_access(input int s, input bit [TW-1:0] t, input bit [31:0] pc,
                                        output bit e_hit, output int e_hw, output int e_vw,
                                        output string rtag);
      int  idx;
      int  h;
      int  pos;
      int  tw;
      bit  old_bit;
      idx = int'((pc >> 2) & 32'h3f);     // R7: PC bits [7:2]
      h = -1;
      for (int w = 0; w < NW; w++) if (m_valid[s][w] && m_tag[s][w] == t) h = w;
      old_bit = m_table[idx];
      if (h >= 0) begin
         pos = 0;
         for (int p = 0; p < NW; p++) if (m_stack[s][p] == h) pos = p;
         m_table[m_pct[s][h]] = (pos != 0);   // R7 deep hit sets, R8 top hit clears
         e_hit = 1; e_hw = h; e_vw = 0; tw = h; rtag = "R2";
      end else begin
         e_vw = -1;
         for (int w = NW - 1; w >= 0; w--) if (!m_valid[s][w]) e_vw = w;
         rtag = "R4";
         if (e_vw < 0) begin
            for (int p = 0; p < NW; p++) if (!m_temp[s][m_stack[s][p]]) e_vw = m_stack[s][p];
            rtag = "R5";
            if (e_vw < 0) begin
               e_vw = m_stack[s][NW-1];
               rtag = "R6";
            end
         end
         e_hit = 0; e_hw = 0; tw = e_vw;   // R10: table untouched on a miss
      end
      m_valid[s][tw] = 1;
      m_tag[s][tw]   = t;
      m_pct[s][tw]   = idx;                // R9
      m_temp[s][tw]  = old_bit;            // R9: value before this access's update
      pos = 0;
      for (int p = 0; p < NW; p++) if (m_stack[s][p] == tw) pos = p;
      for (int p = pos; p > 0; p--) m_stack[s][p] = m_stack[s][p-1];
      m_stack[s][0] = tw;                  // R3
   endfunction

   // ---------------- checking ----------------
   task automatic check(input string r, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   // Drive one access at a falling edge; check its result at the next falling edge.
   task automatic issue(input int s, input bit [TW-1:0] t, input bit [31:0] pc, input string note);
      bit    e_hit;
      int    e_hw;
      int    e_vw;
      string rtag;
      model_access(s, t, pc, e_hit, e_hw, e_vw, rtag);
      req_valid = 1'b1;
      req_set   = 4'(s);
      req_tag   = t;
      req_pc    = pc;
      @(negedge clk);
      check({"R1 ", note}, "rsp_valid", int'(rsp_valid), 1);
      check({rtag, " ", note}, "rsp_hit", int'(rsp_hit), int'(e_hit));
      check({rtag, " ", note}, "rsp_hit_way", int'(rsp_hit_way), e_hw);
      check({rtag, " ", note}, "rsp_victim_way", int'(rsp_victim_way), e_vw);
   endtask

   task automatic idle(input int n);
      req_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check("R1 idle", "rsp_valid", int'(rsp_valid), 0);
      end
   endtask

   localparam bit [31:0] PC_X = 32'h0000_0044;   // index 17
   localparam bit [31:0] PC_Y = 32'h0000_0088;   // index 34
   localparam bit [31:0] PC_Z = 32'h0000_00C0;   // index 48
   localparam bit [31:0] PC_W = 32'h1000_0014;   // index 5

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      bit [31:0] pool [6];
      pool = '{PC_X, PC_Y, PC_Z, PC_W, 32'h0000_0104, 32'h0000_0144};
      void'($urandom(32'd20240611));
      model_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_set = '0; req_tag = '0; req_pc = '0;
      repeat (3) @(negedge clk);
      check("R1 reset", "rsp_valid", int'(rsp_valid), 0);
      check("R1 reset", "req_ready", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R4, R11: back-to-back fills of an empty set take ways 0..3 in order
      issue(0, 20'd1, PC_W, "fill");
      issue(0, 20'd2, PC_W, "fill");
      issue(0, 20'd3, PC_W, "fill");
      issue(0, 20'd4, PC_W, "fill");
      // R7: hit on the oldest line trains index 5; R8: repeat hit at top clears it
      issue(0, 20'd1, PC_W, "deep hit");
      issue(0, 20'd1, PC_W, "top hit R11");
      issue(0, 20'd5, PC_Y, "full-set miss");
      idle(2);

      // R7 training of index 17 in another set
      issue(2, 20'd10, PC_X, "train");
      issue(2, 20'd11, PC_X, "train");
      issue(2, 20'd10, PC_X, "train deep hit");
      // R6: every line filled under a trained PC is temporal, LRU way goes
      issue(1, 20'd20, PC_X, "temporal fill");
      issue(1, 20'd21, PC_X, "temporal fill");
      issue(1, 20'd22, PC_X, "temporal fill");
      issue(1, 20'd23, PC_X, "temporal fill");
      issue(1, 20'd24, PC_Y, "all temporal");
      idle(1);

      // R5: only way 1 is cold, and it is not the LRU way
      issue(3, 20'd30, PC_X, "mixed fill");
      issue(3, 20'd31, PC_Y, "mixed fill");
      issue(3, 20'd32, PC_X, "mixed fill");
      issue(3, 20'd33, PC_X, "mixed fill");
      issue(3, 20'd34, PC_Z, "cold victim");
      // R8: two top hits under PC_X clear index 17
      issue(3, 20'd34, PC_X, "top hit");
      issue(3, 20'd34, PC_X, "top hit clears");
      // retrain index 5, then fill so only way 0 is temporal if R8 held
      issue(7, 20'd70, PC_W, "train");
      issue(7, 20'd71, PC_W, "train");
      issue(7, 20'd70, PC_W, "train deep hit");
      issue(6, 20'd60, PC_W, "fill");
      issue(6, 20'd61, PC_X, "fill after clear");
      issue(6, 20'd62, PC_X, "fill after clear");
      issue(6, 20'd63, PC_X, "fill after clear");
      issue(6, 20'd64, PC_Y, "victim after R8 clear");
      idle(1);

      // R9, R10 and the rest under random traffic
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(3) == 0) begin
            idle(1);
         end else begin
            issue(int'($urandom_range(3)) + 8, TW'($urandom_range(5)),
                  pool[$urandom_range(5)], "random");
         end
      end
      idle(2);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule